// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block runs beside a DRAM access sequencer and decides when the memory needs attention that no client asked for. Once reset is released it holds off all memory traffic for the power-up settling pause. It then asks the sequencer for a fixed number of initialization cycles, each of which must contain a row-strobe pulse. After the last of these is granted it raises `init_done`, and from then on it schedules periodic refreshes so that every row is visited inside the retention window.

Refresh is meant to be carried out in the CAS-before-RAS style, in which the memory's own row counter picks the row. The scheduler therefore keeps no row address and only decides how many refreshes are owed. One request/acknowledge pair serves both the initialization cycles and the refreshes. Interval ticks pile up in a bounded pending counter, so the sequencer can put a refresh off for a while, finish a burst and then pay the debt back. If the debt grows past the bound, a sticky flag reports that a refresh was lost.

All timing comes from a clock-frequency parameter. The pause is rounded up to whole cycles so it is never too short. The refresh interval is rounded down so the deadline is never missed.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ref_req`, `init_done` and `overflow` are all 0.
- R2: After reset is released, `ref_req` and `init_done` stay 0 for exactly PAUSE_CYC clock edges, where PAUSE_CYC = ceil(CLK_HZ × PAUSE_NS / 1e9). `ref_req` goes to 1 on edge number PAUSE_CYC.
- R3: During initialization `ref_req` stays at 1. Each edge on which `ref_ack` and `ref_req` are both 1 counts as one cycle. On the edge that accepts cycle number INIT_CYCLES, `init_done` rises and `ref_req` falls.
- R4: Once `init_done` is 1 it stays 1 until the next reset.
- R5: After initialization a refresh tick occurs every INTERVAL_CYC edges, where INTERVAL_CYC = floor(CLK_HZ × WINDOW_NS / (1e9 × ROWS)). The first tick comes INTERVAL_CYC edges after `init_done` rises. Each tick adds one to the pending count.
- R6: After initialization `ref_req` is 1 exactly when the pending count is non-zero. Each accepted acknowledge removes one pending refresh.
- R7: `ref_ack` has no effect while `ref_req` is 0, whether in the pause or after initialization. The count never drops below zero.
- R8: A tick and an accepted acknowledge on the same edge leave the pending count unchanged.
- R9: The pending count saturates at PEND_MAX. A tick that arrives while the count is at PEND_MAX and no acknowledge is accepted sets `overflow`, which stays 1 until reset.
- R10: A synchronous reset in any phase clears `init_done`, `overflow` and the pending count, and restarts the full pause and initialization sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| ref_ack | input | 1 | Sequencer has started the requested init or refresh cycle |
| ref_req | output | 1 | An init or refresh cycle is owed |
| init_done | output | 1 | Power-up sequence complete; normal access allowed |
| overflow | output | 1 | Sticky: a refresh tick was lost at a full pending count |

## Verification
The bench builds the block at 125 MHz with a pause of 804 ns, which is 100.5 cycles and so becomes 101. It uses a window of 3300 ns over 16 rows, which is 25.78 cycles and so becomes 25, so both rounding directions can be seen at the ports. With PEND_MAX of 4 and INIT_CYCLES of 8, saturation and overflow are reached within about a hundred cycles of initialization. The bench also lines up an acknowledge with a tick, and applies a reset in the middle of a run, which checks that the pause restarts with the same length.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } sched_phase_t;

  localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

  // Settling pause in clock cycles, rounded up so it is never shortened.
  function automatic int unsigned pause_cycles(input longint unsigned hz,
                                               input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + NS_PER_S - 64'd1) / NS_PER_S;
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  // Spacing between refresh ticks, rounded down so the window is never exceeded.
  function automatic int unsigned tick_cycles(input longint unsigned hz,
                                              input longint unsigned window_ns,
                                              input longint unsigned rows);
    longint unsigned c;
    c = (hz * window_ns) / (NS_PER_S * rows);
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned bits_for(input int unsigned v);
    int unsigned b;
    b = $clog2(v + 1);
    if (b < 1) b = 1;
    return b;
  endfunction

endpackage

// File: rtl/rf_tick_timer.sv
module rf_tick_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned W = dram_sched_pkg::bits_for(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // Held at zero while idle, so each run starts a full period.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/rf_init_counter.sv
module rf_init_counter #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic take,
  output logic last
);
  localparam int unsigned W = dram_sched_pkg::bits_for(CYCLES);
  localparam logic [W-1:0] FINAL = W'(CYCLES - 1);

  logic [W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      seen_q <= '0;
    end else if (take && (seen_q != FINAL)) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  assign last = active && take && (seen_q == FINAL);
endmodule

// File: rtl/rf_pending_ctr.sv
module rf_pending_ctr #(
  parameter int unsigned MAX = 8,
  parameter int unsigned W   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         take,
  output logic [W-1:0] count,
  output logic         nz_next,
  output logic         overflow
);
  localparam logic [W-1:0] FULL = W'(MAX);

  logic [W-1:0] count_d;
  logic         lost;

  always_comb begin
    count_d = count;
    lost    = 1'b0;
    unique case ({tick, take})
      2'b10: begin
        if (count == FULL) lost = 1'b1;
        else               count_d = count + 1'b1;
      end
      2'b01: begin
        if (count != '0) count_d = count - 1'b1;
      end
      default: count_d = count;
    endcase
  end

  assign nz_next = (count_d != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      count <= count_d;
      if (lost) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned PAUSE_NS    = 200_000,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned ROWS        = 2048,
  parameter int unsigned WINDOW_NS   = 32_000_000,
  parameter int unsigned PEND_MAX    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_ack,
  output logic ref_req,
  output logic init_done,
  output logic overflow
);
  import dram_sched_pkg::*;

  localparam int unsigned PAUSE_CYC    = pause_cycles(64'(CLK_HZ), 64'(PAUSE_NS));
  localparam int unsigned INTERVAL_CYC = tick_cycles(64'(CLK_HZ), 64'(WINDOW_NS), 64'(ROWS));
  localparam int unsigned PAUSE_W      = bits_for(PAUSE_CYC);
  localparam int unsigned PEND_W       = bits_for(PEND_MAX);

  sched_phase_t phase_q, phase_d;
  logic         req_q, req_d;
  logic         done_q, done_d;

  logic              pause_tick, refresh_tick, init_last;
  logic              take, take_run, pend_nz_next;
  logic [PEND_W-1:0] pend_cnt;

  assign take     = ref_ack && req_q;
  assign take_run = take && (phase_q == PH_RUN);

  rf_tick_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk  (clk),
    .rst  (rst),
    .run  (phase_q == PH_PAUSE),
    .tick (pause_tick)
  );

  rf_init_counter #(.CYCLES(INIT_CYCLES)) u_init (
    .clk    (clk),
    .rst    (rst),
    .active (phase_q == PH_INIT),
    .take   (take),
    .last   (init_last)
  );

  rf_tick_timer #(.LIMIT(INTERVAL_CYC)) u_interval (
    .clk  (clk),
    .rst  (rst),
    .run  (phase_q == PH_RUN),
    .tick (refresh_tick)
  );

  rf_pending_ctr #(.MAX(PEND_MAX), .W(PEND_W)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .tick     (refresh_tick),
    .take     (take_run),
    .count    (pend_cnt),
    .nz_next  (pend_nz_next),
    .overflow (overflow)
  );

  always_comb begin
    phase_d = phase_q;
    req_d   = req_q;
    done_d  = done_q;
    unique case (phase_q)
      PH_PAUSE: begin
        req_d = pause_tick;
        if (pause_tick) phase_d = PH_INIT;
      end
      PH_INIT: begin
        req_d = 1'b1;
        if (init_last) begin
          phase_d = PH_RUN;
          req_d   = 1'b0;
          done_d  = 1'b1;
        end
      end
      PH_RUN: begin
        req_d = pend_nz_next;
      end
      default: begin
        phase_d = PH_PAUSE;
        req_d   = 1'b0;
        done_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_PAUSE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      req_q   <= req_d;
      done_q  <= done_d;
    end
  end

  assign ref_req   = req_q;
  assign init_done = done_q;
endmodule

// File: rtl/rf_sched_checker.sv
module rf_sched_checker #(
  parameter int unsigned PAUSE_CYC = 1,
  parameter int unsigned PAUSE_W   = 1,
  parameter int unsigned PEND_MAX  = 1,
  parameter int unsigned PEND_W    = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_ack,
  input logic              ref_req,
  input logic              init_done,
  input logic              overflow,
  input logic [PEND_W-1:0] pend_cnt
);
  localparam logic [PAUSE_W-1:0] P_END = PAUSE_W'(PAUSE_CYC);
  localparam logic [PEND_W-1:0]  P_MAX = PEND_W'(PEND_MAX);

  // Edges since reset, saturating at the pause length.
  logic [PAUSE_W-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst) since_q <= '0;
    else if (since_q != P_END) since_q <= since_q + 1'b1;
  end

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (rst)
    (since_q < P_END) |-> (!ref_req && !init_done));

  assert_done_on_ack_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(ref_ack && ref_req));

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_req_tracks_count_R6: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (ref_req == (pend_cnt != '0)));

  assert_idle_ack_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (init_done && !ref_req) |=> (pend_cnt <= 1));

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= P_MAX);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_overflow_when_full_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> ($past(pend_cnt) == P_MAX));
endmodule

bind dram_refresh_sched rf_sched_checker #(
  .PAUSE_CYC (PAUSE_CYC),
  .PAUSE_W   (PAUSE_W),
  .PEND_MAX  (PEND_MAX),
  .PEND_W    (PEND_W)
) u_check (
  .clk       (clk),
  .rst       (rst),
  .ref_ack   (ref_ack),
  .ref_req   (ref_req),
  .init_done (init_done),
  .overflow  (overflow),
  .pend_cnt  (pend_cnt)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  localparam int P_INIT = 8;
  localparam int P_MAX  = 4;
  // Expected cycle counts worked out from the requirements (125 MHz clock).
  localparam int EXP_PAUSE = (125 * 804 + 999) / 1000;   // 100.5 -> 101
  localparam int EXP_INT   = (125 * 3300) / (1000 * 16); // 25.78 -> 25

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack = 1'b0;
  logic req, done, ovf;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .CLK_HZ(125_000_000), .PAUSE_NS(804), .INIT_CYCLES(P_INIT),
    .ROWS(16), .WINDOW_NS(3300), .PEND_MAX(P_MAX)
  ) u_dram_refresh_sched (
    .clk(clk), .rst(rst), .ref_ack(ack),
    .ref_req(req), .init_done(done), .overflow(ovf)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int  m_phase = 0, m_t = 0, m_left = P_INIT, m_pend = 0;
  bit  m_req = 0, m_done = 0, m_ovf = 0, m_live = 0;

  always @(posedge clk) begin
    bit acc, tk;
    m_live = 1;
    if (rst) begin
      m_phase = 0; m_t = 0; m_left = P_INIT; m_pend = 0;
      m_req = 0; m_done = 0; m_ovf = 0;
    end else begin
      case (m_phase)
        0: if (m_t == EXP_PAUSE - 1) begin m_phase = 1; m_t = 0; m_req = 1; end
           else m_t++;
        1: if (ack && m_req) begin
             m_left--;
             if (m_left == 0) begin m_phase = 2; m_done = 1; m_req = 0; m_t = 0; end
           end
        default: begin
          acc = ack && m_req;
          tk  = (m_t == EXP_INT - 1);
          m_t = tk ? 0 : m_t + 1;
          if (tk && !acc) begin
            if (m_pend == P_MAX) m_ovf = 1; else m_pend++;
          end else if (acc && !tk) m_pend--;
          m_req = (m_pend != 0);
        end
      endcase
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (m_live) begin
      string tag;
      tag = (m_phase == 0) ? "R2" : (m_phase == 1) ? "R3" : "R6";
      check(req == m_req, tag, "per-cycle ref_req", int'(req), int'(m_req));
      check(done == m_done, "R4", "per-cycle init_done", int'(done), int'(m_done));
      check(ovf == m_ovf, "R9", "per-cycle overflow", int'(ovf), int'(m_ovf));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  // Releases reset and returns the edge count at which ref_req rises.
  task automatic measure_pause(output int n);
    n = 0;
    rst = 1'b0;
    while (!req && n < 1000) begin
      ack = (n == 50);        // stray acknowledge inside the pause
      cyc(1);
      n++;
    end
    ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, acks;
    cyc(2);
    ack = 1'b1; cyc(2); ack = 1'b0; cyc(1);
    check(!req && !done && !ovf, "R1", "outputs in reset", {req, done, ovf}, 0);

    // R2 and R7: pause length, stray acknowledge ignored.
    measure_pause(n);
    check(n == EXP_PAUSE, "R2", "edges until first request", n, EXP_PAUSE);
    check(!done, "R7", "stray ack did not finish init", int'(done), 0);

    // R3: acknowledges spaced out, count until init_done.
    acks = 0;
    for (int k = 0; k < 200 && !done; k++) begin
      ack = req && (k % 2 == 0);
      if (ack) acks++;
      cyc(1);
      ack = 1'b0;
    end
    check(acks == P_INIT, "R3", "acks taken by init", acks, P_INIT);
    check(done && !req, "R3", "done high and req low after init",
          {done, req}, 2);

    // R5: first tick INTERVAL edges after init_done.
    n = 0;
    while (!req && n < 500) begin cyc(1); n++; end
    check(n == EXP_INT, "R5", "edges to first refresh tick", n, EXP_INT);
    ack = 1'b1; cyc(1); ack = 1'b0; n = 1;
    check(!req, "R6", "ack retires the single pending refresh", int'(req), 0);
    while (!req && n < 500) begin cyc(1); n++; end
    check(n == EXP_INT, "R5", "edges between ticks", n, EXP_INT);

    // R8: acknowledge on the same edge as a tick.
    n = 0;
    while (m_t != EXP_INT - 1 && n < 500) begin cyc(1); n++; end
    pulse_ack();
    check(req, "R8", "tick plus ack keeps one pending", int'(req), 1);
    pulse_ack();
    check(!req, "R8", "one ack then clears it", int'(req), 0);

    // R7: acknowledge while idle must not go below zero.
    pulse_ack();
    n = 0;
    while (!req && n < 500) begin cyc(1); n++; end
    pulse_ack();
    check(!req, "R7", "idle ack left count at zero", int'(req), 0);
    check(done, "R4", "init_done still set in run", int'(done), 1);

    // R9: starve the scheduler until saturation and overflow.
    cyc((P_MAX + 1) * EXP_INT + 3);
    check(ovf, "R9", "overflow after lost tick", int'(ovf), 1);
    n = 0;
    while (m_t != 1 && n < 500) begin cyc(1); n++; end
    ack = 1'b1; cyc(P_MAX); ack = 1'b0;
    check(!req, "R9", "count saturated at PEND_MAX", int'(req), 0);
    check(ovf, "R9", "overflow stays set", int'(ovf), 1);

    // R10: reset in the middle of a run restarts everything.
    cyc(7);
    rst = 1'b1; cyc(1);
    check(!req && !done && !ovf, "R10", "outputs cleared by reset",
          {req, done, ovf}, 0);
    measure_pause(n);
    check(n == EXP_PAUSE, "R10", "pause restarts in full", n, EXP_PAUSE);
    check(!done, "R10", "init_done cleared after reset", int'(done), 0);

    cyc(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule